// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit ports, A and B, through an inverting data path. Each port is modelled as three signals: an input, an output and an output enable. Together they stand in for a bidirectional pin. Two holding registers sample the ports. The A-side register loads port A's input when its capture strobe is high, and the B-side register loads port B's input when its own strobe is high. Both registers run on one system clock.

An active-low output enable and a direction input decide which port is driven, if any. With the enable high, both ports are isolated. With the enable low, the direction input picks the port that drives. For each direction a select input decides the source of the driven port. The source is either the live input of the opposite port or the register that holds that port's earlier sample. Whatever is driven appears bit-inverted. Captures take place on every strobe, whatever the enable and direction are.

An active-low asynchronous reset clears both registers. While reset is asserted, both output enables stay inactive.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While rst_ni is low, both registers are cleared to zero and a_oe_o and b_oe_o are 0; with both selects at 1 the outputs then read 0xFF.
- R2: On a clock edge with a_cap_i high, the A-side register loads a_in_i; from the next cycle b_out_o reads its inverse while b_sel_i is 1.
- R3: On a clock edge with b_cap_i high, the B-side register loads b_in_i; from the next cycle a_out_o reads its inverse while a_sel_i is 1.
- R4: Captures occur while oe_ni is 1 (isolation) and while the opposite port is being driven.
- R5: When oe_ni is 1, a_oe_o and b_oe_o are both 0.
- R6: When oe_ni is 0, dir_i = 1 gives b_oe_o = 1 and a_oe_o = 0, and dir_i = 0 gives a_oe_o = 1 and b_oe_o = 0, in the same cycle.
- R7: With b_sel_i = 0, b_out_o equals the bitwise inverse of a_in_i in the same cycle.
- R8: With b_sel_i = 1, b_out_o equals the bitwise inverse of the A-side register.
- R9: a_sel_i = 0 gives a_out_o = ~b_in_i in the same cycle, and a_sel_i = 1 gives a_out_o = the inverse of the B-side register.
- R10: a_oe_o and b_oe_o are never 1 together.
- R11: A register holds its value on every cycle its strobe is low, whatever its port's input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_in_i | input | 8 | Value seen on port A pins |
| b_in_i | input | 8 | Value seen on port B pins |
| a_cap_i | input | 1 | Strobe that loads port A into the A-side register |
| b_cap_i | input | 1 | Strobe that loads port B into the B-side register |
| dir_i | input | 1 | 1: drive B, 0: drive A |
| oe_ni | input | 1 | Output enable, active low |
| a_sel_i | input | 1 | Source for port A: 0 live B, 1 stored B |
| b_sel_i | input | 1 | Source for port B: 0 live A, 1 stored A |
| a_out_o | output | 8 | Inverted data for port A |
| a_oe_o | output | 1 | Port A driver enable |
| b_out_o | output | 8 | Inverted data for port B |
| b_oe_o | output | 1 | Port B driver enable |

## Verification
The live paths are tried with values such as 0x0F, 0x81 and 0x12. These show that the output follows the opposite input in the same cycle, and that every bit is inverted rather than passed through. The stored paths are read after the live input has changed to an unrelated value such as 0xFF. A match there shows that the register is the source, and also that no capture took place while the strobe was low. The two registers are loaded together during isolation and loaded again while the other port is driven. Different values go into each register, so a swapped strobe or a swapped register shows up in the result.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic   rst_ni,
  input  logic   oe_ni,
  input  logic   dir_i,
  output drive_e drv_o
);
  always_comb begin
    drv_o = DRV_NONE;
    if (rst_ni && !oe_ni) drv_o = dir_i ? DRV_B : DRV_A;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_o[i] = ~(sel_i ? held_i[i] : live_i[i]);
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_in_i,
  input  logic [W-1:0] b_in_i,
  input  logic         a_cap_i,
  input  logic         b_cap_i,
  input  logic         dir_i,
  input  logic         oe_ni,
  input  logic         a_sel_i,
  input  logic         b_sel_i,
  output logic [W-1:0] a_out_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_out_o,
  output logic         b_oe_o
);
  logic [W-1:0] a_held, b_held;
  drive_e       drv;

  xcvr_cap_reg #(.W(W)) u_a_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(a_cap_i), .d_i(a_in_i), .q_o(a_held)
  );
  xcvr_cap_reg #(.W(W)) u_b_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(b_cap_i), .d_i(b_in_i), .q_o(b_held)
  );

  xcvr_drive_ctl u_ctl (
    .rst_ni(rst_ni), .oe_ni(oe_ni), .dir_i(dir_i), .drv_o(drv)
  );

  // port B carries A-side data, port A carries B-side data
  xcvr_path #(.W(W)) u_to_b (
    .sel_i(b_sel_i), .live_i(a_in_i), .held_i(a_held), .out_o(b_out_o)
  );
  xcvr_path #(.W(W)) u_to_a (
    .sel_i(a_sel_i), .live_i(b_in_i), .held_i(b_held), .out_o(a_out_o)
  );

  assign a_oe_o = (drv == DRV_A);
  assign b_oe_o = (drv == DRV_B);
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_in_i,
  input logic [W-1:0] b_in_i,
  input logic         a_cap_i,
  input logic         b_cap_i,
  input logic         dir_i,
  input logic         oe_ni,
  input logic         a_sel_i,
  input logic         b_sel_i,
  input logic [W-1:0] a_out_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_out_o,
  input logic         b_oe_o
);
  // R10
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  // R5
  isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o));

  // R6
  dir_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && dir_i) |-> (b_oe_o && !a_oe_o));

  // R2
  a_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_cap_i |=> (!b_sel_i || b_out_o == ~$past(a_in_i)));

  // R3
  b_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_cap_i |=> (!a_sel_i || a_out_o == ~$past(b_in_i)));

  // R11
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_cap_i && b_sel_i) |=> (!b_sel_i || $stable(b_out_o)));
endmodule

bind bus_xcvr_reg xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 8;

  typedef struct {
    logic         a_oe;
    logic         b_oe;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         a_cap, b_cap, dir, oe_n, a_sel, b_sel;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  exp_t         sb_q[$];
  logic [W-1:0] m_a, m_b;
  int           checks = 0;
  int           errors = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  bus_xcvr_reg #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_in_i(a_in), .b_in_i(b_in),
    .a_cap_i(a_cap), .b_cap_i(b_cap), .dir_i(dir), .oe_ni(oe_n),
    .a_sel_i(a_sel), .b_sel_i(b_sel),
    .a_out_o(a_out), .a_oe_o(a_oe), .b_out_o(b_out), .b_oe_o(b_oe)
  );

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push its expected result
  task automatic step(input logic rst, input logic [W-1:0] ai, input logic [W-1:0] bi,
                      input logic ac, input logic bc, input logic d, input logic oen,
                      input logic as, input logic bs, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rst; a_in = ai; b_in = bi; a_cap = ac; b_cap = bc;
    dir = d; oe_n = oen; a_sel = as; b_sel = bs;
    if (!rst) begin m_a = '0; m_b = '0; end
    e.a_oe  = rst && !oen && !d;
    e.b_oe  = rst && !oen && d;
    e.a_out = ~(as ? m_b : bi);
    e.b_out = ~(bs ? m_a : ai);
    e.tag   = tag;
    sb_q.push_back(e);
    @(posedge clk);
    if (rst && ac) m_a = ai;
    if (rst && bc) m_b = bi;
  endtask

  // monitor: compare mid-cycle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, "a_oe", W'(a_oe), W'(e.a_oe));
        cmp(e.tag, "b_oe", W'(b_oe), W'(e.b_oe));
        cmp(e.tag, "a_out", a_out, e.a_out);
        cmp(e.tag, "b_out", b_out, e.b_out);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    m_a = '0; m_b = '0;
    rst_n = 1'b0; a_in = '0; b_in = '0; a_cap = 0; b_cap = 0;
    dir = 1; oe_n = 0; a_sel = 1; b_sel = 1;
    // R1: reset clears registers, enables held low, strobes ignored
    step(0, 8'h77, 8'h66, 1, 1, 1, 0, 1, 1, "R1");
    step(0, 8'h11, 8'h22, 1, 1, 0, 0, 1, 1, "R1");
    // R4 R5: capture both while isolated
    step(1, 8'h3C, 8'hA5, 1, 1, 1, 1, 1, 1, "R4_R5");
    // R2 R3: stored values visible, still isolated
    step(1, 8'h00, 8'h00, 0, 0, 0, 1, 1, 1, "R2_R3");
    // R6 R7: drive B with live A
    step(1, 8'h0F, 8'h00, 0, 0, 1, 0, 1, 0, "R6_R7");
    step(1, 8'h81, 8'h00, 0, 0, 1, 0, 1, 0, "R7");
    // R8 R11: stored A, live input moved, no strobe
    step(1, 8'hFF, 8'h00, 0, 0, 1, 0, 1, 1, "R8_R11");
    // R6 R9: drive A with live B
    step(1, 8'h00, 8'h12, 0, 0, 0, 0, 0, 1, "R6_R9");
    // R9 R11: drive A with stored B
    step(1, 8'h00, 8'h34, 0, 0, 0, 0, 1, 1, "R9_R11");
    // R2 R4: capture A while B is driven
    step(1, 8'h55, 8'h00, 1, 0, 1, 0, 1, 1, "R2_R4");
    step(1, 8'h00, 8'h00, 0, 0, 1, 0, 1, 1, "R2");
    // R3 R4: capture B while A is driven
    step(1, 8'h00, 8'h00, 0, 1, 0, 0, 1, 1, "R3_R4");
    step(1, 8'h00, 8'hC7, 0, 0, 0, 0, 1, 1, "R3");
    // R10 R5: back to isolation
    step(1, 8'h00, 8'h00, 0, 0, 0, 1, 1, 1, "R5_R10");
    @(negedge clk);
    #8;
    finish_run();
  end
endmodule